// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small microcontroller core. When a subroutine call is made or an interrupt is taken, the core presents its current program counter. The stack stores that value plus one on its top level. When a return executes, the core loads the top entry, which is always visible on the read port, and strobes a pop.

Calls, interrupts and a table-read instruction all draw on one pool of six 13-bit levels. The table-read instruction briefly borrows one level and then releases it. The stack pointer is exported so that the core can see how deep the nesting is. A push into a full stack and a pop from an empty stack each set a sticky error flag. A push and a pop in the same cycle replace the top entry.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset, sp_o is 6 (empty), ret_addr_o is 0, and ovf_o, unf_o and busy_o are all 0.
- R2: sp_o stays in the range 0 to 6. A value of 6 means empty and 0 means full. While the stack is not empty, ret_addr_o shows the entry at index sp_o. While it is empty, ret_addr_o shows 0.
- R3: A push (push_i or tmp_push_i alone) into a stack that is not full decrements sp_o by one and writes addr_i+1 into the new top. The new value appears on ret_addr_o in the next cycle.
- R4: A pop (pop_i or tmp_rel_i alone) from a stack that is not empty increments sp_o by one. The value on ret_addr_o just before the popping edge is the returned address.
- R5: A push and a pop in the same cycle on a stack that is not empty overwrite the top with addr_i+1 and leave sp_o unchanged. On an empty stack the same pair acts as a plain push and does not set unf_o.
- R6: A push alone into a full stack leaves sp_o and every entry unchanged and sets ovf_o. ovf_o stays set until reset.
- R7: A pop alone from an empty stack leaves sp_o unchanged and sets unf_o. unf_o stays set until reset.
- R8: An accepted tmp_push_i sets busy_o and tmp_rel_i clears it. In every other respect the two strobes act exactly like a push and a pop.
- R9: Pushes made for calls, interrupts and temporary use all count against the same six levels.
- R10: The stored return address wraps modulo 2^13, so pushing 8191 stores 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Push for a call or an interrupt |
| pop_i | input | 1 | Pop for a return |
| tmp_push_i | input | 1 | Temporary push for a table read |
| tmp_rel_i | input | 1 | Release of the temporary level |
| addr_i | input | 13 | Current program counter |
| ret_addr_o | output | 13 | Top entry (return address) |
| sp_o | output | 3 | Stack pointer, 6 means empty |
| ovf_o | output | 1 | Sticky overflow flag |
| unf_o | output | 1 | Sticky underflow flag |
| busy_o | output | 1 | Temporary level held |

## Verification
A push and a pop can arrive in the same cycle. This can happen as a call together with a return, or as a temporary push together with its release. The bench drives both strobes on one edge, once on a stack holding one entry and once on an empty stack. It then judges the result by sp_o and ret_addr_o: the first case must show a replaced top with an unchanged pointer, and the second must show a plain push with unf_o still clear.

// File: rtl/rstk_pkg.sv
package rstk_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_PUSH, OP_POP, OP_REPL} op_e;
endpackage

// File: rtl/rstk_ptr.sv
module rstk_ptr
  import rstk_pkg::*;
#(
  parameter int DEPTH = 6,
  localparam int SPW = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  output op_e            op_o,
  output logic [SPW-1:0] sp_o,
  output logic           ovf_o,
  output logic           unf_o
);
  localparam logic [SPW-1:0] SP_EMPTY = SPW'(DEPTH);
  localparam logic [SPW-1:0] SP_ONE   = SPW'(1);

  logic [SPW-1:0] sp_q;
  logic           ovf_q, unf_q, ovf_ev, unf_ev, empty, full;
  op_e            op;

  assign empty = (sp_q == SP_EMPTY);
  assign full  = (sp_q == '0);

  always_comb begin
    op     = OP_NONE;
    ovf_ev = 1'b0;
    unf_ev = 1'b0;
    if (push_i && pop_i && !empty) op = OP_REPL;
    else if (push_i) begin
      if (full) ovf_ev = 1'b1;
      else      op = OP_PUSH;
    end else if (pop_i) begin
      if (empty) unf_ev = 1'b1;
      else       op = OP_POP;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= SP_EMPTY;
      ovf_q <= 1'b0;
      unf_q <= 1'b0;
    end else begin
      unique case (op)
        OP_PUSH: sp_q <= sp_q - SP_ONE;
        OP_POP:  sp_q <= sp_q + SP_ONE;
        default: sp_q <= sp_q;
      endcase
      if (ovf_ev) ovf_q <= 1'b1;
      if (unf_ev) unf_q <= 1'b1;
    end
  end

  assign op_o  = op;
  assign sp_o  = sp_q;
  assign ovf_o = ovf_q;
  assign unf_o = unf_q;

  AST_SP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_q <= SP_EMPTY); // R2
  AST_PUSH_DEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !full) |=> (sp_q == $past(sp_q) - SP_ONE)); // R3
  AST_POP_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty) |=> (sp_q == $past(sp_q) + SP_ONE)); // R4
  AST_REPL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i && !empty) |=> $stable(sp_q)); // R5
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |=> ovf_q); // R6
  AST_UNF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_q |=> unf_q); // R7
  AST_UNF_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && empty) |=> (unf_q && $stable(sp_q))); // R7
endmodule

// File: rtl/rstk_mem.sv
module rstk_mem
  import rstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 13,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  op_e            op_i,
  input  logic [SPW-1:0] sp_i,
  input  logic [AW-1:0]  wdata_i,
  output logic [AW-1:0]  rdata_o
);
  logic [AW-1:0]  ent_q [DEPTH];
  logic [SPW-1:0] waddr;
  logic           we;

  assign we    = (op_i == OP_PUSH) || (op_i == OP_REPL);
  assign waddr = (op_i == OP_PUSH) ? sp_i - SPW'(1) : sp_i;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       ent_q[g] <= '0;
      else if (we && waddr == SPW'(g))   ent_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (sp_i == SPW'(i)) rdata_o = ent_q[i];
  end

  AST_WR_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (waddr < SPW'(DEPTH))); // R2
endmodule

// File: rtl/rstk_tmp.sv
module rstk_tmp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tmp_push_i,
  input  logic tmp_rel_i,
  input  logic accept_i,
  output logic busy_o
);
  logic busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= (busy_q && !tmp_rel_i) || (tmp_push_i && accept_i);
  end

  assign busy_o = busy_q;

  AST_BUSY_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(tmp_push_i)); // R8
  AST_BUSY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmp_rel_i && !tmp_push_i) |=> !busy_q); // R8
endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack
  import rstk_pkg::*;
#(
  parameter int DEPTH = 6,
  parameter int AW    = 13,
  localparam int SPW  = $clog2(DEPTH + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic           pop_i,
  input  logic           tmp_push_i,
  input  logic           tmp_rel_i,
  input  logic [AW-1:0]  addr_i,
  output logic [AW-1:0]  ret_addr_o,
  output logic [SPW-1:0] sp_o,
  output logic           ovf_o,
  output logic           unf_o,
  output logic           busy_o
);
  logic          push_any, pop_any, accept;
  logic [AW-1:0] wdata;
  op_e           op;

  assign push_any = push_i | tmp_push_i;
  assign pop_any  = pop_i | tmp_rel_i;
  assign wdata    = addr_i + AW'(1);
  assign accept   = (op == OP_PUSH) || (op == OP_REPL);

  rstk_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni, .push_i(push_any), .pop_i(pop_any),
    .op_o(op), .sp_o, .ovf_o, .unf_o
  );

  rstk_mem #(.DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk_i, .rst_ni, .op_i(op), .sp_i(sp_o), .wdata_i(wdata), .rdata_o(ret_addr_o)
  );

  rstk_tmp u_tmp (
    .clk_i, .rst_ni, .tmp_push_i, .tmp_rel_i, .accept_i(accept), .busy_o
  );

  AST_FULL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_any && !pop_any && sp_o == '0) |=> ($stable(ret_addr_o) && sp_o == '0 && ovf_o)); // R6
  AST_EMPTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sp_o == SPW'(DEPTH)) |-> (ret_addr_o == '0)); // R2
  AST_PUSH_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_any && sp_o != '0) |=> (ret_addr_o == $past(addr_i) + AW'(1))); // R3
endmodule

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push = 0, pop = 0, tpush = 0, trel = 0;
  logic [12:0] addr = '0;
  logic [12:0] ret;
  logic [2:0]  sp;
  logic        ovf, unf, busy;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_addr_stack u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_i(push), .pop_i(pop),
    .tmp_push_i(tpush), .tmp_rel_i(trel), .addr_i(addr),
    .ret_addr_o(ret), .sp_o(sp), .ovf_o(ovf), .unf_o(unf), .busy_o(busy)
  );

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive strobes for one edge, then sample a quarter period later
  task automatic step(bit p, bit q, bit tp, bit tr, int a);
    push = p; pop = q; tpush = tp; trel = tr; addr = 13'(a);
    @(posedge clk);
    #(CLK_PERIOD/4);
    push = 0; pop = 0; tpush = 0; trel = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #(CLK_PERIOD);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1", "sp", sp, 6);
    check("R1", "ret", ret, 0);
    check("R1", "ovf", ovf, 0);
    check("R1", "unf", unf, 0);
    check("R1", "busy", busy, 0);
  endtask

  task automatic t_lifo();
    step(1, 0, 0, 0, 100);
    check("R3", "sp", sp, 5);
    check("R3", "ret", ret, 101);
    step(1, 0, 0, 0, 200);
    check("R3", "sp", sp, 4);
    check("R2", "ret top", ret, 201);
    step(0, 1, 0, 0, 0);
    check("R4", "sp", sp, 5);
    check("R4", "ret", ret, 101);
    step(0, 1, 0, 0, 0);
    check("R4", "sp", sp, 6);
    check("R2", "ret empty", ret, 0);
  endtask

  task automatic t_fill_ovf();
    // mixed sources share six levels: 3 calls, 1 temp, 2 more calls
    step(1, 0, 0, 0, 10);
    step(1, 0, 0, 0, 11);
    step(1, 0, 0, 0, 12);
    step(0, 0, 1, 0, 13);
    check("R8", "busy", busy, 1);
    step(1, 0, 0, 0, 14);
    step(1, 0, 0, 0, 15);
    check("R9", "sp full", sp, 0);
    check("R9", "ret", ret, 16);
    check("R6", "ovf pre", ovf, 0);
    step(1, 0, 0, 0, 999);
    check("R6", "sp", sp, 0);
    check("R6", "ret", ret, 16);
    check("R6", "ovf", ovf, 1);
    for (int i = 0; i < 6; i++) begin
      check("R9", "pop value", ret, 16 - i);
      step(0, 1, 0, 0, 0);
    end
    check("R9", "sp drained", sp, 6);
    check("R6", "ovf sticky", ovf, 1);
    check("R7", "unf clear", unf, 0);
    do_reset();
  endtask

  task automatic t_unf();
    step(0, 1, 0, 0, 0);
    check("R7", "sp", sp, 6);
    check("R7", "unf", unf, 1);
    step(1, 0, 0, 0, 40);
    check("R7", "unf sticky", unf, 1);
    check("R3", "sp after", sp, 5);
    do_reset();
  endtask

  task automatic t_repl();
    step(1, 0, 0, 0, 50);
    step(1, 1, 0, 0, 70);
    check("R5", "sp", sp, 5);
    check("R5", "ret", ret, 71);
    step(0, 1, 0, 0, 0);
    check("R5", "sp empty", sp, 6);
    step(1, 1, 0, 0, 5);
    check("R5", "empty sp", sp, 5);
    check("R5", "empty ret", ret, 6);
    check("R5", "no unf", unf, 0);
    step(0, 1, 0, 0, 0);
  endtask

  task automatic t_tmp();
    step(1, 0, 0, 0, 300);
    step(0, 0, 1, 0, 400);
    check("R8", "busy", busy, 1);
    check("R8", "sp", sp, 4);
    check("R8", "ret", ret, 401);
    step(0, 0, 0, 1, 0);
    check("R8", "busy clr", busy, 0);
    check("R8", "sp", sp, 5);
    check("R8", "ret", ret, 301);
    step(0, 1, 0, 0, 0);
  endtask

  task automatic t_wrap();
    step(1, 0, 0, 0, 8191);
    check("R10", "sp", sp, 5);
    check("R10", "ret", ret, 0);
    step(0, 1, 0, 0, 0);
    check("R10", "sp", sp, 6);
  endtask

  initial begin
    t_reset();
    t_lifo();
    t_fill_ovf();
    t_unf();
    t_repl();
    t_tmp();
    t_wrap();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule